// File: doc/BRIEF.md
# Windowed key-sequence watchdog timer

This block is a watchdog counter that asks for a system reset when software stops servicing it. Software services it by two writes to a service register: first the byte 0x55, then the byte 0xAA. A completed pair restarts the count from zero. Any other byte, a 0xAA that was not armed by a 0x55, or an expired count raises a one-cycle reset request. Bus decoding, the reset generator and the slow oscillator are outside the block.

The count runs either on a slow tick-enable pulse of about 1 kHz, or on every cycle of the system clock. A two-bit select picks one of three timeouts per source, or switches the watchdog off. With the fast source an optional window mode is available. In that mode a service write that arrives before the last quarter of the period is itself a reset cause. The configuration inputs behave like write-once option bits. They are captured only on clock edges while reset is held, and any later change has no effect.

Top module: `wdt_keyseq`

## Requirements
- R1: A 0xAA write made while a 0x55 is armed completes the key and restarts the count from zero. The next timeout then comes a full period after the edge that took the 0xAA.
- R2: While the watchdog is enabled, a service write of any byte other than 0x55 or 0xAA raises the reset request on the next cycle.
- R3: A 0xAA write is out of order, and raises the request, unless the service write just before it was a 0x55. A second 0x55 keeps the key armed.
- R4: When the count reaches the selected timeout without a completed key, the request is raised. The timeouts for select 01, 10 and 11 are 32, 256 and 1024 ticks on the slow source, and 2^13, 2^16 and 2^18 cycles on the bus clock.
- R5: With the slow source (bus select input 0), the count advances only on edges where tick_en_i is 1. With the bus clock (input 1), it advances on every edge.
- R6: Select 00 switches the watchdog off. No request is ever raised, and service writes have no effect.
- R7: In window mode (bus clock, window input 1), a service write made while the count is below three quarters of the period raises the request. For selects 01, 10 and 11 that threshold is 6144, 49152 and 196608. A write made at or above it is accepted.
- R8: With the slow source, the window input is ignored and service writes are accepted at any count.
- R9: rst_req_o is high for one cycle per event. In the same edge the count and the armed state return to zero, so the next timeout is a full period later.
- R10: The configuration inputs are captured on each clock edge while rst_ni is 0. Changes made after reset is released are ignored.
- R11: With the inputs at their default levels (select 11, slow source, window 0), the watchdog is enabled with a timeout of 1024 ticks.
- R12: A key completed on the very edge where the count would expire wins, and no request is raised. A bad write on that edge gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset; configuration is captured while low |
| tick_en_i | input | 1 | Slow tick-enable pulse of about 1 kHz |
| svc_wr_i | input | 1 | Service-register write strobe |
| svc_data_i | input | 8 | Byte written to the service register |
| cfg_tsel_i | input | 2 | Timeout select: 00 off, 01 short, 10 middle, 11 long |
| cfg_bus_clk_i | input | 1 | 1 selects the bus clock as count source, 0 selects the slow tick |
| cfg_window_i | input | 1 | Window enable, honoured only with the bus clock |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two of the block's functions can fall on the same edge: key completion or key checking, and counter expiry. The bench provokes this by holding the count at one below the timeout and then issuing the service write. It does this once with a closing 0xAA in window mode, and once with an illegal byte on the slow source with a tick on every cycle. For the completion case it checks that no request appears and that a full new period follows. For the illegal byte it checks that exactly one pulse appears and that the next timeout lands a full period after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Timeout select encoding, shared by the decoder and the top level
   typedef enum logic [1:0] {
      SEL_OFF   = 2'b00,
      SEL_SHORT = 2'b01,
      SEL_MID   = 2'b10,
      SEL_LONG  = 2'b11
   } wdt_sel_e;

   // Captured option bits
   typedef struct packed {
      wdt_sel_e sel;
      logic     bus_clk;
      logic     window;
   } wdt_cfg_t;

   localparam int unsigned WDT_NUM_SEL = 4;

endpackage

// File: rtl/wdt_cfg_latch.sv
module wdt_cfg_latch
   import wdt_pkg::*;
#(
   parameter bit WINDOW_SUPPORT = 1'b1
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  wdt_cfg_t cfg_i,
   output wdt_cfg_t cfg_o
);

   wdt_cfg_t cfg_q;

   // Option bits load only while reset is held (write-once model)
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q <= cfg_i;
      end
   end

   assign cfg_o.sel     = cfg_q.sel;
   assign cfg_o.bus_clk = cfg_q.bus_clk;

   generate
      if (WINDOW_SUPPORT) begin : g_win
         // window only meaningful with the fast source
         assign cfg_o.window = cfg_q.window & cfg_q.bus_clk;
      end else begin : g_nowin
         logic unused_win;
         assign unused_win   = cfg_q.window;
         assign cfg_o.window = 1'b0;
      end
   endgenerate

   // R10: once running, the captured options never move
   a_r10_cfg_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> $stable(cfg_q));

   // R8: an effective window implies the bus clock source
   a_r8_window_needs_bus : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o.window |-> cfg_o.bus_clk);

endmodule

// File: rtl/wdt_limit_dec.sv
module wdt_limit_dec
   import wdt_pkg::*;
#(
   parameter int unsigned SLOW_EXP_1 = 5,
   parameter int unsigned SLOW_EXP_2 = 8,
   parameter int unsigned SLOW_EXP_3 = 10,
   parameter int unsigned BUS_EXP_1  = 13,
   parameter int unsigned BUS_EXP_2  = 16,
   parameter int unsigned BUS_EXP_3  = 18,
   parameter int unsigned CNT_W      = 18
) (
   input  wdt_cfg_t         cfg_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] limit_m1_o,
   output logic             win_ok_o
);

   localparam int unsigned SLOW_EXP [WDT_NUM_SEL] = '{0, SLOW_EXP_1, SLOW_EXP_2, SLOW_EXP_3};
   localparam int unsigned BUS_EXP  [WDT_NUM_SEL] = '{0, BUS_EXP_1, BUS_EXP_2, BUS_EXP_3};

   // Elaboration-time parameter checks
   if (!(SLOW_EXP_1 < SLOW_EXP_2 && SLOW_EXP_2 < SLOW_EXP_3)) begin : g_bad_slow
      $error("slow exponents must rise strictly");
   end
   if (!(BUS_EXP_1 < BUS_EXP_2 && BUS_EXP_2 < BUS_EXP_3)) begin : g_bad_bus
      $error("bus exponents must rise strictly");
   end
   if (BUS_EXP_1 < 2) begin : g_bad_quarter
      $error("bus period must be divisible into quarters");
   end
   if (BUS_EXP_3 > CNT_W || SLOW_EXP_3 > CNT_W || CNT_W > 62) begin : g_bad_width
      $error("counter width does not fit the longest period");
   end

   logic [CNT_W-1:0] slow_lim [WDT_NUM_SEL];
   logic [CNT_W-1:0] bus_lim  [WDT_NUM_SEL];
   logic [CNT_W-1:0] bus_open [WDT_NUM_SEL];

   assign slow_lim[0] = '0;
   assign bus_lim[0]  = '0;
   assign bus_open[0] = '0;

   // One constant triple per non-off select
   for (genvar g = 1; g < WDT_NUM_SEL; g++) begin : g_sel
      localparam longint unsigned SL = (64'd1 << SLOW_EXP[g]) - 64'd1;
      localparam longint unsigned BL = (64'd1 << BUS_EXP[g]) - 64'd1;
      localparam longint unsigned BO = 64'd3 << (BUS_EXP[g] - 2);
      assign slow_lim[g] = CNT_W'(SL);
      assign bus_lim[g]  = CNT_W'(BL);
      assign bus_open[g] = CNT_W'(BO);
   end

   logic [CNT_W-1:0] open_sel;

   always_comb begin
      limit_m1_o = cfg_i.bus_clk ? bus_lim[cfg_i.sel] : slow_lim[cfg_i.sel];
      open_sel   = bus_open[cfg_i.sel];
      win_ok_o   = !cfg_i.window || (count_i >= open_sel);
   end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 18
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             advance_i,
   input  logic [CNT_W-1:0] limit_m1_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   logic [CNT_W-1:0] count_q;

   assign expire_o = advance_i && (count_q == limit_m1_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) begin
         count_q <= '0;
      end else if (advance_i) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;

   // R4: the count never runs past the selected period
   a_r4_within_limit : assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= limit_m1_i);

   // R5: without an advance or clear the count holds
   a_r5_hold_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!advance_i && !clear_i) |=> $stable(count_q));

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h55,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hAA
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              win_ok_i,
   input  logic              clr_i,
   output logic              done_o,
   output logic              fault_o
);

   if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
      $error("the two key bytes must differ");
   end

   logic armed_q;
   logic act, is_first, is_second;

   assign act       = wr_i && en_i;
   assign is_first  = (data_i == KEY_FIRST);
   assign is_second = (data_i == KEY_SECOND);

   always_comb begin
      fault_o = act && (!(is_first || is_second) || !win_ok_i || (is_second && !armed_q));
      done_o  = act && is_second && armed_q && win_ok_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i || fault_o || done_o) begin
         armed_q <= 1'b0;
      end else if (act && is_first) begin
         armed_q <= 1'b1;
      end
   end

   // R3: an accepted first key leaves the sequence armed
   a_r3_first_arms : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act && is_first && win_ok_i && !clr_i) |=> armed_q);

   // R9: any fault disarms the sequence
   a_r9_fault_disarms : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |=> !armed_q);

   // R12: completion and fault never coincide
   a_r12_done_xor_fault : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(done_o && fault_o));

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned SLOW_EXP_1     = 5,
   parameter int unsigned SLOW_EXP_2     = 8,
   parameter int unsigned SLOW_EXP_3     = 10,
   parameter int unsigned BUS_EXP_1      = 13,
   parameter int unsigned BUS_EXP_2      = 16,
   parameter int unsigned BUS_EXP_3      = 18,
   parameter bit          WINDOW_SUPPORT = 1'b1,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h55,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hAA
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_en_i,
   input  logic              svc_wr_i,
   input  logic [DATA_W-1:0] svc_data_i,
   input  logic [1:0]        cfg_tsel_i,
   input  logic              cfg_bus_clk_i,
   input  logic              cfg_window_i,
   output logic              rst_req_o
);

   localparam int unsigned CNT_W = (BUS_EXP_3 > SLOW_EXP_3) ? BUS_EXP_3 : SLOW_EXP_3;

   if (DATA_W < 2) begin : g_bad_dw
      $error("data width too small for the key bytes");
   end

   wdt_cfg_t         cfg_in, cfg;
   logic [CNT_W-1:0] count, limit_m1;
   logic             win_ok, expire, key_done, key_fault;
   logic             enabled, advance, req_d, req_q;

   assign cfg_in.sel     = wdt_sel_e'(cfg_tsel_i);
   assign cfg_in.bus_clk = cfg_bus_clk_i;
   assign cfg_in.window  = cfg_window_i;

   wdt_cfg_latch #(
      .WINDOW_SUPPORT (WINDOW_SUPPORT)
   ) cfg_latch_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg_in),
      .cfg_o  (cfg)
   );

   wdt_limit_dec #(
      .SLOW_EXP_1 (SLOW_EXP_1),
      .SLOW_EXP_2 (SLOW_EXP_2),
      .SLOW_EXP_3 (SLOW_EXP_3),
      .BUS_EXP_1  (BUS_EXP_1),
      .BUS_EXP_2  (BUS_EXP_2),
      .BUS_EXP_3  (BUS_EXP_3),
      .CNT_W      (CNT_W)
   ) limit_dec_i (
      .cfg_i      (cfg),
      .count_i    (count),
      .limit_m1_o (limit_m1),
      .win_ok_o   (win_ok)
   );

   assign enabled = (cfg.sel != SEL_OFF);
   assign advance = enabled && (cfg.bus_clk || tick_en_i);

   wdt_key_seq #(
      .DATA_W     (DATA_W),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) key_seq_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (enabled),
      .wr_i     (svc_wr_i),
      .data_i   (svc_data_i),
      .win_ok_i (win_ok),
      .clr_i    (req_d),
      .done_o   (key_done),
      .fault_o  (key_fault)
   );

   // A completed key on the expiry edge outranks the expiry
   assign req_d = enabled && (key_fault || (expire && !key_done));

   wdt_counter #(
      .CNT_W (CNT_W)
   ) counter_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (key_done || req_d),
      .advance_i  (advance),
      .limit_m1_i (limit_m1),
      .count_o    (count),
      .expire_o   (expire)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
      end else begin
         req_q <= req_d;
      end
   end

   assign rst_req_o = req_q;

   // R2: an illegal byte leads to a request on the next cycle
   a_r2_bad_byte : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc_wr_i && enabled && svc_data_i != KEY_FIRST && svc_data_i != KEY_SECOND)
      |=> rst_req_o);

   // R7: a write before the window opens leads to a request
   a_r7_early_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc_wr_i && enabled && cfg.window && !win_ok) |=> rst_req_o);

   // R1: completion restarts the count and raises nothing
   a_r1_restart : assert property (@(posedge clk_i) disable iff (!rst_ni)
      key_done |=> (count == '0 && !rst_req_o));

   // R6: switched off means silent
   a_r6_off_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enabled |=> !rst_req_o);

   // R9: a request coincides with a cleared count
   a_r9_clear_on_req : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> count == '0);

endmodule

// File: tb/wdt_keyseq_tb_top.sv
module wdt_keyseq_tb_top;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       tick_en = 1'b0;
   logic       svc_wr = 1'b0;
   logic [7:0] svc_data = 8'h00;
   logic [1:0] tsel = 2'b11;
   logic       bus_clk = 1'b0;
   logic       window = 1'b0;
   logic       rst_req;

   int n_chk = 0;
   int n_fail = 0;
   int cyc_no = 0;
   int adv = 0;
   int tick_per = 2;
   bit bus_mode = 1'b0;

   always #2 clk = ~clk;

   wdt_keyseq dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_ni),
      .tick_en_i     (tick_en),
      .svc_wr_i      (svc_wr),
      .svc_data_i    (svc_data),
      .cfg_tsel_i    (tsel),
      .cfg_bus_clk_i (bus_clk),
      .cfg_window_i  (window),
      .rst_req_o     (rst_req)
   );

   typedef struct packed {
      logic [1:0]  sel;
      logic        bus;
      logic        win;
      logic [19:0] pre;
      logic [7:0]  data;
      logic        exp;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t TBL [NVEC] = '{
      '{2'b11, 1'b0, 1'b0, 20'd5,     8'h33, 1'b1},  // R2 illegal byte
      '{2'b11, 1'b0, 1'b0, 20'd5,     8'h55, 1'b0},  // R1 first key accepted
      '{2'b11, 1'b0, 1'b0, 20'd5,     8'hAA, 1'b1},  // R3 unarmed second key
      '{2'b01, 1'b1, 1'b1, 20'd100,   8'h55, 1'b1},  // R7 early in window mode
      '{2'b01, 1'b1, 1'b0, 20'd100,   8'h55, 1'b0},  // R7 no window, no fault
      '{2'b01, 1'b0, 1'b1, 20'd3,     8'h55, 1'b0},  // R8 window ignored on slow
      '{2'b00, 1'b0, 1'b0, 20'd3,     8'h12, 1'b0},  // R6 off ignores bad byte
      '{2'b00, 1'b1, 1'b1, 20'd3,     8'hAA, 1'b0},  // R6 off ignores everything
      '{2'b01, 1'b1, 1'b1, 20'd6143,  8'h55, 1'b1},  // R7 one below threshold
      '{2'b01, 1'b1, 1'b1, 20'd6144,  8'h55, 1'b0},  // R7 at threshold
      '{2'b10, 1'b1, 1'b1, 20'd49151, 8'h55, 1'b1}   // R7 middle select threshold
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock: count advances at the edge, then drive at the falling edge
   task automatic cyc();
      @(posedge clk);
      if (rst_ni) adv += (bus_mode ? 1 : int'(tick_en));
      @(negedge clk);
      cyc_no++;
      tick_en = (tick_per > 0) ? ((cyc_no % tick_per) == 0) : 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic do_reset(input logic [1:0] s, input logic b, input logic w);
      rst_ni = 1'b0;
      svc_wr = 1'b0;
      tsel = s;
      bus_clk = b;
      window = w;
      bus_mode = b;
      idle(3);
      chk(rst_req == 1'b0, "R9 reset state", int'(rst_req), 0);
      rst_ni = 1'b1;
      adv = 0;
   endtask

   task automatic write(input logic [7:0] d);
      svc_wr = 1'b1;
      svc_data = d;
      cyc();
      svc_wr = 1'b0;
   endtask

   // Caller sets adv to zero at the zero point of the period
   task automatic expect_timeout(input int n, input string req);
      bit early = 1'b0;
      while (adv < n) begin
         cyc();
         if (adv < n && rst_req) early = 1'b1;
      end
      chk(!early, req, int'(early), 0);
      chk(rst_req == 1'b1, req, int'(rst_req), 1);
      cyc();
      chk(rst_req == 1'b0, "R9 single pulse", int'(rst_req), 0);
   endtask

   initial begin
      // table walk
      for (int i = 0; i < NVEC; i++) begin
         tick_per = 2;
         do_reset(TBL[i].sel, TBL[i].bus, TBL[i].win);
         idle(int'(TBL[i].pre));
         write(TBL[i].data);
         chk(rst_req == TBL[i].exp, $sformatf("vector %0d (R1/R2/R3/R6/R7/R8)", i),
             int'(rst_req), int'(TBL[i].exp));
      end

      // R4 R5 R10: slow short period, tick every 4th cycle, inputs changed after release
      tick_per = 4;
      do_reset(2'b01, 1'b0, 1'b0);
      tsel = 2'b00;
      bus_clk = 1'b1;
      expect_timeout(32, "R4 R5 R10 slow 32 ticks");

      // R4: slow middle period, tick every cycle
      tick_per = 1;
      do_reset(2'b10, 1'b0, 1'b0);
      expect_timeout(256, "R4 slow 256 ticks");

      // R11: default levels
      tick_per = 2;
      do_reset(2'b11, 1'b0, 1'b0);
      expect_timeout(1024, "R11 default 1024 ticks");

      // R4: bus middle period
      do_reset(2'b10, 1'b1, 1'b0);
      expect_timeout(65536, "R4 bus 2^16 cycles");

      // R1 R3: repeated first key then second key restarts the period
      do_reset(2'b01, 1'b1, 1'b0);
      idle(8000);
      write(8'h55);
      write(8'h55);
      write(8'hAA);
      chk(rst_req == 1'b0, "R3 repeated first key stays armed", int'(rst_req), 0);
      adv = 0;
      expect_timeout(8192, "R1 restart after key");

      // R12: key completed on the expiry edge in window mode
      do_reset(2'b01, 1'b1, 1'b1);
      idle(8000);
      write(8'h55);
      idle(190);
      write(8'hAA);
      chk(rst_req == 1'b0, "R12 completion on expiry edge", int'(rst_req), 0);
      adv = 0;
      expect_timeout(8192, "R12 full period after late completion");

      // R12 R9: bad byte on the expiry edge, slow source ticking every cycle
      tick_per = 1;
      do_reset(2'b01, 1'b0, 1'b0);
      idle(31);
      write(8'h33);
      chk(rst_req == 1'b1, "R12 fault on expiry edge", int'(rst_req), 1);
      adv = 0;
      expect_timeout(32, "R9 count cleared by request");

      // R8: full key right after reset on slow source with window input high
      tick_per = 2;
      do_reset(2'b01, 1'b0, 1'b1);
      idle(2);
      write(8'h55);
      write(8'hAA);
      chk(rst_req == 1'b0, "R8 early key accepted on slow source", int'(rst_req), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule